// File: doc/BRIEF.md
# Search Engine Register File

This block is the register bank that sits beside a ternary search array. It holds 64 register slots, each 68 bits wide, on a 6-bit address. The low 32 slots are comparand storage, grouped as 16 even/odd pairs. A search presents its key as two halves on the data bus in two consecutive cycles. The first half (phase A) goes into the even register of the chosen pair. The second half (phase B) goes into the odd register of the same pair. A later learn operation reads a whole pair back through a dedicated port.

The host reaches every slot through a register access port. Reads have one cycle of latency. The mask pairs, the command word and the two burst control words can be written. The comparands, the eight search-hit index words, the information word and the next-free-address word are read-only to the host. The internal status producers load those status words through their own update ports. The three top addresses are reserved.

Top module: `se_regfile`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, every register reads zero. rd_data is zero, and both learn outputs are zero for every pair.
- R2: A capture strobe with cap_phase_b=0 (phase A) writes key_data into comparand register 2*cap_pair (address 2*cap_pair) at that clock edge.
- R3: A capture strobe with cap_phase_b=1 (phase B) in the cycle right after a phase-A strobe writes key_data into register 2*p+1. Here p is the pair given with the phase-A strobe, and the cap_pair value of the phase-B cycle is ignored.
- R4: A phase-B strobe that does not directly follow a phase-A strobe changes no register. This includes a phase B after an idle cycle and a second phase B in a row.
- R5: learn_key_a shows register 2*learn_pair and learn_key_b shows register 2*learn_pair+1, with no added clock cycle.
- R6: A host write to a read-only or reserved address changes no register. These addresses are comparands 0..31, search-hit indexes 48..55, information 57, next-free address 60 and reserved 61..63.
- R7: A host write to a mask address (32..47), to the command word (56) or to a burst word (58, 59) stores host_wdata, and a later read returns it.
- R8: When host_rd is high at a clock edge, rd_data at that edge takes the addressed register's value from before the edge, so a write at the same edge is not yet seen. When host_rd is low, rd_data holds.
- R9: Reads from addresses 61..63 return zero.
- R10: ssi_upd_en loads ssi_upd_data into address 48+ssi_upd_sel, info_upd_en loads address 57, and nfa_upd_en loads address 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Search key capture strobe |
| cap_phase_b | input | 1 | 0 = phase A (even half), 1 = phase B (odd half) |
| cap_pair | input | 4 | Comparand pair index, used in phase A |
| key_data | input | 68 | Search key half |
| learn_pair | input | 4 | Pair to present on the learn port |
| learn_key_a | output | 68 | Even register of learn_pair |
| learn_key_b | output | 68 | Odd register of learn_pair |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 6 | Host register address |
| host_wdata | input | 68 | Host write data |
| rd_data | output | 68 | Registered host read data |
| ssi_upd_en | input | 1 | Search-hit index update strobe |
| ssi_upd_sel | input | 3 | Search-hit index register select |
| ssi_upd_data | input | 68 | Search-hit index update value |
| info_upd_en | input | 1 | Information word update strobe |
| info_upd_data | input | 68 | Information word update value |
| nfa_upd_en | input | 1 | Next-free address update strobe |
| nfa_upd_data | input | 68 | Next-free address update value |

## Verification
The bench aims at the phase-B rules. It gives a phase B whose cap_pair differs from the phase A before it, a phase B after an idle cycle, and two phase B strobes in a row. A design that used the live pair would write the wrong odd slot, and one without the phase-A link would overwrite a stale pair. It writes to every class of read-only and reserved address and reads the slot back, so a wrong decode shows up as a changed value. It also issues a read and a write to the same address at one edge, where a design with a bypass path would return the new value too early.

// File: rtl/se_regs_pkg.sv
package se_regs_pkg;

  localparam int REG_W      = 68;
  localparam int ADDR_W     = 6;
  localparam int COMP_PAIRS = 16;
  localparam int MASK_COUNT = 16;
  localparam int SSI_COUNT  = 8;

  localparam int COMP_BASE = 0;
  localparam int MASK_BASE = COMP_BASE + 2 * COMP_PAIRS;
  localparam int SSI_BASE  = MASK_BASE + MASK_COUNT;
  localparam int CMD_ADDR  = SSI_BASE + SSI_COUNT;
  localparam int INFO_ADDR = CMD_ADDR + 1;
  localparam int BRD_ADDR  = CMD_ADDR + 2;
  localparam int BWR_ADDR  = CMD_ADDR + 3;
  localparam int NFA_ADDR  = CMD_ADDR + 4;

  typedef enum logic [3:0] {
    RG_COMP,
    RG_MASK,
    RG_SSI,
    RG_CMD,
    RG_INFO,
    RG_BRD,
    RG_BWR,
    RG_NFA,
    RG_RSVD
  } reg_region_e;

  function automatic reg_region_e region_of(input logic [ADDR_W-1:0] a);
    int ai;
    ai = int'(a);
    if (ai < MASK_BASE)       return RG_COMP;
    else if (ai < SSI_BASE)   return RG_MASK;
    else if (ai < CMD_ADDR)   return RG_SSI;
    else if (ai == CMD_ADDR)  return RG_CMD;
    else if (ai == INFO_ADDR) return RG_INFO;
    else if (ai == BRD_ADDR)  return RG_BRD;
    else if (ai == BWR_ADDR)  return RG_BWR;
    else if (ai == NFA_ADDR)  return RG_NFA;
    else                      return RG_RSVD;
  endfunction

  function automatic logic host_can_write(input reg_region_e r);
    return (r == RG_MASK) || (r == RG_CMD) || (r == RG_BRD) || (r == RG_BWR);
  endfunction

endpackage

// File: rtl/se_addr_decode.sv
module se_addr_decode
  import se_regs_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic          wr_req,
  output reg_region_e   region,
  output logic          wr_ok
);

  always_comb begin
    region = region_of(addr);
    wr_ok  = wr_req && host_can_write(region);
  end

endmodule

// File: rtl/se_comp_bank.sv
module se_comp_bank #(
  parameter int W     = 68,
  parameter int PAIRS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic                       cap_phase_b,
  input  logic [$clog2(PAIRS)-1:0]   cap_pair,
  input  logic [W-1:0]               key_data,
  input  logic [$clog2(PAIRS)-1:0]   learn_pair,
  output logic [W-1:0]               learn_key_a,
  output logic [W-1:0]               learn_key_b,
  input  logic [$clog2(2*PAIRS)-1:0] rd_slot,
  output logic [W-1:0]               rd_val,
  output logic                       a_fire,
  output logic                       b_fire
);

  localparam int SLOTS  = 2 * PAIRS;
  localparam int PAIR_W = $clog2(PAIRS);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [W-1:0]      slot_q [SLOTS];
  logic              armed_q;
  logic [PAIR_W-1:0] held_pair_q;
  logic [SLOT_W-1:0] wr_slot;
  logic              wr_any;

  assign a_fire  = cap_en && !cap_phase_b;
  assign b_fire  = cap_en && cap_phase_b && armed_q;
  assign wr_any  = a_fire || b_fire;
  assign wr_slot = a_fire ? {cap_pair, 1'b0} : {held_pair_q, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      held_pair_q <= '0;
    end else begin
      armed_q <= a_fire;
      if (a_fire) held_pair_q <= cap_pair;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (wr_any && (wr_slot == SLOT_W'(s)))
        slot_q[s] <= key_data;
    end
  end

  assign learn_key_a = slot_q[{learn_pair, 1'b0}];
  assign learn_key_b = slot_q[{learn_pair, 1'b1}];
  assign rd_val      = slot_q[rd_slot];

endmodule

// File: rtl/se_ctrl_bank.sv
module se_ctrl_bank
  import se_regs_pkg::*;
#(
  parameter int W      = 68,
  parameter int MASKS  = 16,
  parameter int SSI_N  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_ok,
  input  reg_region_e                region,
  input  logic [$clog2(MASKS)-1:0]   mask_idx,
  input  logic [$clog2(SSI_N)-1:0]   ssi_idx,
  input  logic [W-1:0]               wdata,
  input  logic                       ssi_upd_en,
  input  logic [$clog2(SSI_N)-1:0]   ssi_upd_sel,
  input  logic [W-1:0]               ssi_upd_data,
  input  logic                       info_upd_en,
  input  logic [W-1:0]               info_upd_data,
  input  logic                       nfa_upd_en,
  input  logic [W-1:0]               nfa_upd_data,
  output logic [W-1:0]               rd_val
);

  localparam int MIW = $clog2(MASKS);
  localparam int SIW = $clog2(SSI_N);

  logic [W-1:0] mask_q [MASKS];
  logic [W-1:0] ssi_q  [SSI_N];
  logic [W-1:0] cmd_q, brd_q, bwr_q, info_q, nfa_q;

  for (genvar m = 0; m < MASKS; m++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)
        mask_q[m] <= '0;
      else if (wr_ok && region == RG_MASK && mask_idx == MIW'(m))
        mask_q[m] <= wdata;
    end
  end

  for (genvar k = 0; k < SSI_N; k++) begin : g_ssi
    always_ff @(posedge clk) begin
      if (!rst_n)
        ssi_q[k] <= '0;
      else if (ssi_upd_en && ssi_upd_sel == SIW'(k))
        ssi_q[k] <= ssi_upd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      brd_q  <= '0;
      bwr_q  <= '0;
      info_q <= '0;
      nfa_q  <= '0;
    end else begin
      if (wr_ok && region == RG_CMD) cmd_q <= wdata;
      if (wr_ok && region == RG_BRD) brd_q <= wdata;
      if (wr_ok && region == RG_BWR) bwr_q <= wdata;
      if (info_upd_en) info_q <= info_upd_data;
      if (nfa_upd_en)  nfa_q  <= nfa_upd_data;
    end
  end

  always_comb begin
    case (region)
      RG_MASK: rd_val = mask_q[mask_idx];
      RG_SSI:  rd_val = ssi_q[ssi_idx];
      RG_CMD:  rd_val = cmd_q;
      RG_INFO: rd_val = info_q;
      RG_BRD:  rd_val = brd_q;
      RG_BWR:  rd_val = bwr_q;
      RG_NFA:  rd_val = nfa_q;
      default: rd_val = '0;
    endcase
  end

endmodule

// File: rtl/se_regfile.sv
module se_regfile
  import se_regs_pkg::*;
#(
  parameter int W     = REG_W,
  parameter int AW    = ADDR_W,
  parameter int PAIRS = COMP_PAIRS,
  parameter int MASKS = MASK_COUNT,
  parameter int SSI_N = SSI_COUNT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic                       cap_phase_b,
  input  logic [$clog2(PAIRS)-1:0]   cap_pair,
  input  logic [W-1:0]               key_data,
  input  logic [$clog2(PAIRS)-1:0]   learn_pair,
  output logic [W-1:0]               learn_key_a,
  output logic [W-1:0]               learn_key_b,
  input  logic                       host_wr,
  input  logic                       host_rd,
  input  logic [AW-1:0]              host_addr,
  input  logic [W-1:0]               host_wdata,
  output logic [W-1:0]               rd_data,
  input  logic                       ssi_upd_en,
  input  logic [$clog2(SSI_N)-1:0]   ssi_upd_sel,
  input  logic [W-1:0]               ssi_upd_data,
  input  logic                       info_upd_en,
  input  logic [W-1:0]               info_upd_data,
  input  logic                       nfa_upd_en,
  input  logic [W-1:0]               nfa_upd_data
);

  localparam int SLOT_W = $clog2(2 * PAIRS);
  localparam int MIW    = $clog2(MASKS);
  localparam int SIW    = $clog2(SSI_N);

  reg_region_e  region;
  logic         host_wr_accept;
  logic         cap_a_fire;
  logic         cap_b_fire;
  logic [W-1:0] comp_rd;
  logic [W-1:0] ctrl_rd;
  logic [W-1:0] rd_q;

  se_addr_decode #(.AW(AW)) u_dec (
    .addr   (host_addr),
    .wr_req (host_wr),
    .region (region),
    .wr_ok  (host_wr_accept)
  );

  se_comp_bank #(.W(W), .PAIRS(PAIRS)) u_comp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (cap_en),
    .cap_phase_b (cap_phase_b),
    .cap_pair    (cap_pair),
    .key_data    (key_data),
    .learn_pair  (learn_pair),
    .learn_key_a (learn_key_a),
    .learn_key_b (learn_key_b),
    .rd_slot     (host_addr[SLOT_W-1:0]),
    .rd_val      (comp_rd),
    .a_fire      (cap_a_fire),
    .b_fire      (cap_b_fire)
  );

  se_ctrl_bank #(.W(W), .MASKS(MASKS), .SSI_N(SSI_N)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ok         (host_wr_accept),
    .region        (region),
    .mask_idx      (host_addr[MIW-1:0]),
    .ssi_idx       (host_addr[SIW-1:0]),
    .wdata         (host_wdata),
    .ssi_upd_en    (ssi_upd_en),
    .ssi_upd_sel   (ssi_upd_sel),
    .ssi_upd_data  (ssi_upd_data),
    .info_upd_en   (info_upd_en),
    .info_upd_data (info_upd_data),
    .nfa_upd_en    (nfa_upd_en),
    .nfa_upd_data  (nfa_upd_data),
    .rd_val        (ctrl_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_q <= '0;
    else if (host_rd)
      rd_q <= (region == RG_COMP) ? comp_rd :
              (region == RG_RSVD) ? '0 : ctrl_rd;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/se_regfile_checker.sv
module se_regfile_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         cap_b_fire,
  input logic         cap_a_fire,
  input logic         host_wr_accept,
  input logic         host_rd,
  input logic [5:0]   host_addr,
  input logic [3:0]   cap_pair,
  input logic [3:0]   learn_pair,
  input logic [67:0]  key_data,
  input logic [67:0]  learn_key_a,
  input logic [67:0]  learn_key_b,
  input logic [67:0]  rd_data
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> rd_data == 68'd0);

  p_even_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a_fire && cap_pair == learn_pair) |=>
      ($stable(learn_pair) |-> learn_key_a == $past(key_data)));

  p_b_follows_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_b_fire |-> $past(cap_a_fire));

  p_odd_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_b_fire && $past(cap_pair) == learn_pair) |=>
      ($stable(learn_pair) |-> learn_key_b == $past(key_data)));

  p_write_allowed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_accept |-> ((host_addr >= 6'd32 && host_addr <= 6'd47) ||
                        host_addr == 6'd56 || host_addr == 6'd58 ||
                        host_addr == 6'd59));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(rd_data));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr >= 6'd61) |=> rd_data == 68'd0);

endmodule

bind se_regfile se_regfile_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cap_b_fire     (cap_b_fire),
  .cap_a_fire     (cap_a_fire),
  .host_wr_accept (host_wr_accept),
  .host_rd        (host_rd),
  .host_addr      (host_addr),
  .cap_pair       (cap_pair),
  .learn_pair     (learn_pair),
  .key_data       (key_data),
  .learn_key_a    (learn_key_a),
  .learn_key_b    (learn_key_b),
  .rd_data        (rd_data)
);

// File: tb/se_regfile_tb.sv
module se_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_en = 1'b0, cap_phase_b = 1'b0;
  logic [3:0]  cap_pair = '0, learn_pair = '0;
  logic [67:0] key_data = '0;
  logic [67:0] learn_key_a, learn_key_b, rd_data;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [67:0] host_wdata = '0;
  logic        ssi_upd_en = 1'b0, info_upd_en = 1'b0, nfa_upd_en = 1'b0;
  logic [2:0]  ssi_upd_sel = '0;
  logic [67:0] ssi_upd_data = '0, info_upd_data = '0, nfa_upd_data = '0;

  always #5 clk = ~clk;

  se_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_phase_b(cap_phase_b),
    .cap_pair(cap_pair), .key_data(key_data), .learn_pair(learn_pair),
    .learn_key_a(learn_key_a), .learn_key_b(learn_key_b),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .rd_data(rd_data),
    .ssi_upd_en(ssi_upd_en), .ssi_upd_sel(ssi_upd_sel), .ssi_upd_data(ssi_upd_data),
    .info_upd_en(info_upd_en), .info_upd_data(info_upd_data),
    .nfa_upd_en(nfa_upd_en), .nfa_upd_data(nfa_upd_data)
  );

  int total = 0;
  int bad = 0;
  bit tracking = 1'b0;
  bit finished = 1'b0;

  // Behavioural reference: a flat 64-entry view of the address space
  logic [67:0] mdl [64];
  logic [67:0] exp_rd;
  bit          mdl_armed;
  int          mdl_pair;

  function automatic bit host_may_write(int a);
    return (a >= 32 && a <= 47) || a == 56 || a == 58 || a == 59;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mdl[i] = '0;
      exp_rd = '0;
      mdl_armed = 1'b0;
      mdl_pair = 0;
    end else begin
      if (host_rd) exp_rd = (int'(host_addr) >= 61) ? 68'd0 : mdl[int'(host_addr)];
      if (host_wr && host_may_write(int'(host_addr))) mdl[int'(host_addr)] = host_wdata;
      if (ssi_upd_en) mdl[48 + int'(ssi_upd_sel)] = ssi_upd_data;
      if (info_upd_en) mdl[57] = info_upd_data;
      if (nfa_upd_en) mdl[60] = nfa_upd_data;
      if (cap_en && !cap_phase_b) begin
        mdl[2 * int'(cap_pair)] = key_data;
        mdl_armed = 1'b1;
        mdl_pair = int'(cap_pair);
      end else if (cap_en && cap_phase_b && mdl_armed) begin
        mdl[2 * mdl_pair + 1] = key_data;
        mdl_armed = 1'b0;
      end else begin
        mdl_armed = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [67:0] got, input logic [67:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (tracking) begin
      chk("R8 rd_data vs model", rd_data, exp_rd);
      chk("R5 learn_key_a vs model", learn_key_a, mdl[2 * int'(learn_pair)]);
      chk("R5 learn_key_b vs model", learn_key_b, mdl[2 * int'(learn_pair) + 1]);
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic capture(input logic ph, input logic [3:0] p, input logic [67:0] d);
    cap_en = 1'b1; cap_phase_b = ph; cap_pair = p; key_data = d;
    tick();
    cap_en = 1'b0;
  endtask

  task automatic hwrite(input logic [5:0] a, input logic [67:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [5:0] a, input logic [67:0] exp, input string req);
    host_rd = 1'b1; host_addr = a;
    tick();
    host_rd = 1'b0;
    chk(req, rd_data, exp);
  endtask

  task automatic learn_chk(input logic [3:0] p, input logic [67:0] ea,
                           input logic [67:0] eb, input string req);
    learn_pair = p;
    #1;
    chk(req, learn_key_a, ea);
    chk(req, learn_key_b, eb);
  endtask

  function automatic logic [67:0] pat(int n);
    return {4'hA, 32'(n * 32'h9E37_79B9), 32'(n ^ 32'h5A5A_0F0F)};
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired, all requirements unfinished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: values during reset
    chk("R1 rd_data in reset", rd_data, 68'd0);
    learn_chk(4'd7, 68'd0, 68'd0, "R1 learn in reset");
    rst_n = 1'b1;
    tracking = 1'b1;
    tick();
    chk("R1 rd_data after reset", rd_data, 68'd0);
    hread(6'd33, 68'd0, "R1 mask reads zero");
    hread(6'd56, 68'd0, "R1 command reads zero");

    // R2: phase A into even slot
    capture(1'b0, 4'd3, pat(1));
    hread(6'd6, pat(1), "R2 even slot of pair 3");
    hread(6'd7, 68'd0, "R2 odd slot untouched");

    // R3: phase B uses pair held from phase A
    capture(1'b0, 4'd5, pat(2));
    capture(1'b1, 4'd9, pat(3));
    hread(6'd11, pat(3), "R3 odd slot of held pair 5");
    hread(6'd19, 68'd0, "R3 live pair 9 ignored");
    learn_chk(4'd5, pat(2), pat(3), "R5 learn pair 5");

    // R4: stray phase B
    capture(1'b1, 4'd2, pat(4));
    hread(6'd5, 68'd0, "R4 lone phase B");
    capture(1'b0, 4'd1, pat(5));
    tick();
    capture(1'b1, 4'd1, pat(6));
    hread(6'd3, 68'd0, "R4 phase B after idle");
    capture(1'b0, 4'd0, pat(7));
    capture(1'b1, 4'd0, pat(8));
    capture(1'b1, 4'd0, pat(9));
    hread(6'd1, pat(8), "R4 second phase B ignored");

    // R6: writes to read-only and reserved addresses
    hwrite(6'd6, pat(10));
    hwrite(6'd50, pat(11));
    hwrite(6'd57, pat(12));
    hwrite(6'd60, pat(13));
    hwrite(6'd62, pat(14));
    hread(6'd6, pat(1), "R6 comparand write dropped");
    hread(6'd50, 68'd0, "R6 index write dropped");
    hread(6'd57, 68'd0, "R6 info write dropped");
    hread(6'd60, 68'd0, "R6 next-free write dropped");

    // R7: writable registers
    hwrite(6'd32, pat(20));
    hwrite(6'd47, pat(21));
    hwrite(6'd56, pat(22));
    hwrite(6'd58, pat(23));
    hwrite(6'd59, pat(24));
    hread(6'd32, pat(20), "R7 first mask");
    hread(6'd47, pat(21), "R7 last mask");
    hread(6'd56, pat(22), "R7 command");
    hread(6'd58, pat(23), "R7 burst read word");
    hread(6'd59, pat(24), "R7 burst write word");

    // R9: reserved reads
    hread(6'd61, 68'd0, "R9 reserved 61");
    hread(6'd63, 68'd0, "R9 reserved 63");

    // R8: read sees pre-edge value; hold when idle
    host_rd = 1'b1; host_wr = 1'b1; host_addr = 6'd40; host_wdata = pat(30);
    tick();
    host_rd = 1'b0; host_wr = 1'b0;
    chk("R8 same-edge write not visible", rd_data, 68'd0);
    host_addr = 6'd47;
    tick();
    chk("R8 rd_data holds without read", rd_data, 68'd0);
    hread(6'd40, pat(30), "R8 write visible next read");

    // R10: status update ports
    ssi_upd_en = 1'b1; ssi_upd_sel = 3'd7; ssi_upd_data = pat(40);
    info_upd_en = 1'b1; info_upd_data = pat(41);
    nfa_upd_en = 1'b1; nfa_upd_data = pat(42);
    tick();
    ssi_upd_en = 1'b0; info_upd_en = 1'b0; nfa_upd_en = 1'b0;
    hread(6'd55, pat(40), "R10 index register 7");
    hread(6'd57, pat(41), "R10 information word");
    hread(6'd60, pat(42), "R10 next-free word");

    // Mixed random traffic, compared against the model every clock
    for (int n = 0; n < 600; n++) begin
      cap_en      = ($urandom % 3) != 0;
      cap_phase_b = $urandom % 2;
      cap_pair    = 4'($urandom);
      key_data    = {4'($urandom), $urandom, $urandom};
      host_wr     = $urandom % 2;
      host_rd     = $urandom % 2;
      host_addr   = 6'($urandom);
      host_wdata  = {4'($urandom), $urandom, $urandom};
      learn_pair  = 4'($urandom);
      ssi_upd_en  = ($urandom % 4) == 0;
      ssi_upd_sel = 3'($urandom);
      ssi_upd_data = {4'($urandom), $urandom, $urandom};
      info_upd_en = ($urandom % 8) == 0;
      info_upd_data = {4'($urandom), $urandom, $urandom};
      nfa_upd_en  = ($urandom % 8) == 0;
      nfa_upd_data = {4'($urandom), $urandom, $urandom};
      tick();
    end
    cap_en = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    ssi_upd_en = 1'b0; info_upd_en = 1'b0; nfa_upd_en = 1'b0;
    tick();
    tick();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule